// File: doc/BRIEF.md
# Single-Wire Memory Command Controller

This block is the byte-level command engine of a serial memory slave on a single-wire bus. A bit-level layer below it recovers whole bytes and the bus start and stop events, and hands them over one cycle at a time. For every byte it receives, the controller decides whether the slave pulls the acknowledge slot low (ACK) or leaves it high (NACK). Those answers carry status, not just framing: the lock-check answer reports the lock state, a speed query reports the current mode, and a locked part refuses the data byte of a security-register write.

The controller decodes the device address byte: an opcode, the slave address and a direction flag. It runs five commands: security-register write, the one-way security lock, the lock check, the speed set and the speed query. It holds a sticky lock flag and a speed-mode flag. The speed flag goes to the bit layer, which uses it to pick its slot timing. A security-register write reaches storage as a one-cycle write strobe on a register-file port. The memory array and the electrical timing are handled elsewhere.

Top module: `swc_cmd_ctrl`

## Requirements
- R1: Each cycle with `byte_vld` high (and no start or stop event) is followed in the next cycle by exactly one `resp_vld` pulse carrying the answer in `resp_ack` (1 = ACK). `resp_vld` is never high at any other time.
- R2: Device address byte layout: bits 7:4 opcode, bits 3:1 slave address, bit 0 direction (1 = read). A slave-address mismatch, an unknown opcode, or an opcode used with the wrong direction (lock or security write with bit 0 = 1) is NACKed. Every later byte is then NACKed, with no write and no flag change, until the next start.
- R3: For a security write (opcode 1011b, bit 0 = 0), the device byte and the following word-address byte are both ACKed, locked or not.
- R4: When unlocked, the data byte of a security write is ACKed. In the same cycle as that answer, `reg_we` pulses for one cycle with `reg_addr` set to the low ADDR_W bits of the word address and `reg_wdata` set to the data byte. Later bytes of the same transaction are NACKed.
- R5: When locked, the data byte of a security write is NACKed and causes no write. Later bytes are NACKed until a new start.
- R6: Lock command (opcode 0010b, bit 0 = 0): the next byte must carry 0110b in bits 7:4, or it is NACKed and the transaction is dropped. When unlocked, that tagged byte is ACKed, and the data byte after it is ACKed and sets the lock.
- R7: Lock check: the 0110b-tagged byte answers ACK when unlocked and NACK when locked. Ending with a stop after that byte leaves the lock unchanged.
- R8: Once set, the lock stays set through any command, abort or stop; only `rst_n` clears it. A lock command on a locked part gets NACK on its tagged byte and on its data byte.
- R9: Opcode 1101b with bit 0 = 0 selects standard speed (`speed_hs` = 0). Opcode 1110b with bit 0 = 0 selects high speed (`speed_hs` = 1). Both are ACKed, and `speed_hs` changes in the same cycle as the answer.
- R10: Opcode 1101b with bit 0 = 1 is ACKed only when standard speed is active. Opcode 1110b with bit 0 = 1 is ACKed only when high speed is active. A query changes no state.
- R11: After reset, `speed_hs` = 1, the lock is clear, and `resp_vld` and `reg_we` are 0.
- R12: A start event in the middle of a command abandons it, and the next byte is decoded as a device byte. A stop event abandons it too, and bytes are then NACKed until a start. Bytes that arrive before any start are NACKed. No abandoned command writes or changes a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr | input | 3 | Strapped slave address compared against bits 3:1 |
| start_evt | input | 1 | One-cycle pulse: start condition seen |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| byte_vld | input | 1 | One-cycle pulse: `byte_data` holds a complete received byte |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| resp_vld | output | 1 | Answer for the previous cycle's byte is valid |
| resp_ack | output | 1 | 1 = ACK (pull slot low), 0 = NACK |
| reg_we | output | 1 | One-cycle security-register write strobe |
| reg_addr | output | ADDR_W | Security-register write address |
| reg_wdata | output | 8 | Security-register write data |
| speed_hs | output | 1 | 1 = high-speed mode, 0 = standard speed |

## Verification
A corrupted lock flag first shows up on the lock-check answer or on the third byte of a security write. That answer comes one cycle after the byte, so the error appears at the first such transaction and can stay hidden through any amount of speed traffic. A wrong speed flag shows on `speed_hs` right away and flips the next speed-query answer. A command state that skips or repeats a phase shifts every later ACK in the transaction by one byte, and a spurious or missing `reg_we` pulse shows in the same cycle as the data byte's answer.

// File: rtl/swc_pkg.sv
// Package: shared encodings for the single-wire command controller.
// Assumes: opcode nibble in bits 7:4 of the device byte, direction in bit 0.
package swc_pkg;

    localparam logic [3:0] OPC_LOCK   = 4'b0010;
    localparam logic [3:0] OPC_SECWR  = 4'b1011;
    localparam logic [3:0] OPC_STD    = 4'b1101;
    localparam logic [3:0] OPC_HS     = 4'b1110;
    localparam logic [3:0] LOCK_TAG   = 4'b0110;

    // Command selected by a device address byte.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_SECWR,
        CMD_LOCK,
        CMD_SET_STD,
        CMD_SET_HS,
        CMD_ASK_STD,
        CMD_ASK_HS
    } swc_cmd_e;

    // Position of the controller inside a transaction.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_SEC_ADDR,
        ST_SEC_DATA,
        ST_LK_ADDR,
        ST_LK_DATA,
        ST_DRAIN
    } swc_state_e;

endpackage

// File: rtl/swc_dev_decode.sv
// Module: swc_dev_decode
// Purely combinational decode of a device address byte into a command.
// Assumes: the caller only uses the result while a device byte is expected.
module swc_dev_decode
    import swc_pkg::*;
(
    input  logic [7:0] dev_byte,
    input  logic [2:0] strap_addr,
    output swc_cmd_e   cmd
);

    logic       addr_hit;
    logic [3:0] opc;
    logic       rd;

    assign opc      = dev_byte[7:4];
    assign rd       = dev_byte[0];
    assign addr_hit = (dev_byte[3:1] == strap_addr);

    // Map opcode and direction to a command; anything else is refused.
    always_comb begin
        cmd = CMD_NONE;
        if (addr_hit) begin
            unique case ({opc, rd})
                {OPC_SECWR, 1'b0}: cmd = CMD_SECWR;
                {OPC_LOCK,  1'b0}: cmd = CMD_LOCK;
                {OPC_STD,   1'b0}: cmd = CMD_SET_STD;
                {OPC_STD,   1'b1}: cmd = CMD_ASK_STD;
                {OPC_HS,    1'b0}: cmd = CMD_SET_HS;
                {OPC_HS,    1'b1}: cmd = CMD_ASK_HS;
                default:           cmd = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/swc_mode_flags.sv
// Module: swc_mode_flags
// Holds the sticky lock flag and the speed-mode flag.
// Assumes: set strobes are single-cycle and the two speed strobes never coincide.
module swc_mode_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_lock,
    input  logic set_std,
    input  logic set_hs,
    output logic lock_q,
    output logic hs_q
);

    // Lock only ever sets; reset is the single way back.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_q <= 1'b0;
        else if (set_lock) lock_q <= 1'b1;
    end

    // Speed mode follows the last set command; high speed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       hs_q <= 1'b1;
        else if (set_std) hs_q <= 1'b0;
        else if (set_hs)  hs_q <= 1'b1;
    end

    // R8: the lock never falls outside reset.
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R9: a standard-speed select leaves the flag low next cycle.
    a_r9_std_select: assert property (@(posedge clk) disable iff (!rst_n)
        set_std |=> !hs_q);

    // R9: the two speed selects are exclusive.
    a_r9_one_speed: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_std && set_hs));

endmodule

// File: rtl/swc_cmd_ctrl.sv
// Module: swc_cmd_ctrl (top)
// Byte-level command engine: walks each transaction, answers every byte with
// ACK/NACK one cycle later, issues security-register writes and drives flags.
// Assumes: start_evt, stop_evt and byte_vld never coincide; if they do, the
// event wins and the byte is dropped.
module swc_cmd_ctrl
    import swc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap_addr,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    output logic              resp_vld,
    output logic              resp_ack,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              speed_hs
);

    localparam int AW = (ADDR_W > 8) ? 8 : ADDR_W;

    swc_state_e  state_q, nxt_c;
    swc_cmd_e    cmd_c;
    logic        take_c;
    logic        ack_c, we_c;
    logic        lock_c, std_c, hs_c;
    logic        lock_q;
    logic [AW-1:0] waddr_q;

    swc_dev_decode dec_i (
        .dev_byte   (byte_data),
        .strap_addr (strap_addr),
        .cmd        (cmd_c)
    );

    // A byte counts only when no bus event competes with it.
    assign take_c = byte_vld && !start_evt && !stop_evt;

    // Answer, next phase and side effects for the byte being received.
    always_comb begin
        ack_c  = 1'b0;
        we_c   = 1'b0;
        lock_c = 1'b0;
        std_c  = 1'b0;
        hs_c   = 1'b0;
        nxt_c  = ST_DRAIN;
        unique case (state_q)
            ST_IDLE: nxt_c = ST_IDLE;
            ST_DEV: begin
                unique case (cmd_c)
                    CMD_SECWR:   begin ack_c = 1'b1; nxt_c = ST_SEC_ADDR; end
                    CMD_LOCK:    begin ack_c = 1'b1; nxt_c = ST_LK_ADDR;  end
                    CMD_SET_STD: begin ack_c = 1'b1; std_c = 1'b1;        end
                    CMD_SET_HS:  begin ack_c = 1'b1; hs_c  = 1'b1;        end
                    CMD_ASK_STD: ack_c = !speed_hs;
                    CMD_ASK_HS:  ack_c = speed_hs;
                    default:     ack_c = 1'b0;
                endcase
            end
            ST_SEC_ADDR: begin ack_c = 1'b1; nxt_c = ST_SEC_DATA; end
            ST_SEC_DATA: begin ack_c = !lock_q; we_c = !lock_q; end
            ST_LK_ADDR: begin
                if (byte_data[7:4] == LOCK_TAG && !lock_q) begin
                    ack_c = 1'b1;
                    nxt_c = ST_LK_DATA;
                end
            end
            ST_LK_DATA: begin ack_c = !lock_q; lock_c = !lock_q; end
            default: nxt_c = ST_DRAIN;
        endcase
    end

    // Transaction sequencing, response register and write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            resp_vld  <= 1'b0;
            resp_ack  <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
            waddr_q   <= '0;
        end else begin
            resp_vld <= 1'b0;
            reg_we   <= 1'b0;
            if (start_evt) begin
                state_q <= ST_DEV;
            end else if (stop_evt) begin
                state_q <= ST_IDLE;
            end else if (byte_vld) begin
                resp_vld <= 1'b1;
                resp_ack <= ack_c;
                state_q  <= nxt_c;
                if (state_q == ST_SEC_ADDR) waddr_q <= byte_data[AW-1:0];
                if (we_c) begin
                    reg_we    <= 1'b1;
                    reg_wdata <= byte_data;
                end
            end
        end
    end

    assign reg_addr = ADDR_W'(waddr_q);

    swc_mode_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lock (take_c && lock_c),
        .set_std  (take_c && std_c),
        .set_hs   (take_c && hs_c),
        .lock_q   (lock_q),
        .hs_q     (speed_hs)
    );

    // R1: every accepted byte gets an answer in the next cycle.
    a_r1_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take_c |=> resp_vld);

    // R1: no answer without a byte in the cycle before.
    a_r1_no_stray_answer: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> $past(byte_vld));

    // R4: a write strobe always rides on an ACK.
    a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (resp_vld && resp_ack));

    // R5: nothing is written while the lock is set.
    a_r5_no_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !lock_q);

    // R12: a start event yields no answer in the following cycle.
    a_r12_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !resp_vld);

endmodule

// File: tb/swc_cmd_ctrl_tb_top.sv
// Bench for swc_cmd_ctrl: table-driven transactions, then directed tests.
module swc_cmd_ctrl_tb_top;

    localparam int ADDR_W = 5;
    localparam logic [2:0] STRAP = 3'b101;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_evt = 1'b0;
    logic              stop_evt = 1'b0;
    logic              byte_vld = 1'b0;
    logic [7:0]        byte_data = 8'h00;
    logic              resp_vld, resp_ack, reg_we, speed_hs;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0]        reg_wdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    swc_cmd_ctrl #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_addr(STRAP),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .resp_vld(resp_vld), .resp_ack(resp_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .speed_hs(speed_hs)
    );

    // Entry: [24:23] kind (0 byte, 1 start, 2 stop), [22:15] byte,
    // [14] ack, [13] write, [12] speed_hs after, [11:4] word addr, [3:0] req.
    function automatic logic [24:0] fB(input logic [7:0] d, input logic a,
        input logic w, input logic h, input logic [7:0] wa, input logic [3:0] r);
        return {2'd0, d, a, w, h, wa, r};
    endfunction
    function automatic logic [24:0] fS();
        return {2'd1, 23'd0};
    endfunction
    function automatic logic [24:0] fP();
        return {2'd2, 23'd0};
    endfunction

    localparam int NV = 63;
    localparam logic [24:0] VEC [NV] = '{
        fS(), fB(8'hEB,1'b1,1'b0,1'b1,8'h00,4'd10), fP(),               // R10 hs query
        fS(), fB(8'hDB,1'b0,1'b0,1'b1,8'h00,4'd10), fP(),               // R10 std query
        fS(), fB(8'hDA,1'b1,1'b0,1'b0,8'h00,4'd9),  fP(),               // R9 set std
        fS(), fB(8'hDB,1'b1,1'b0,1'b0,8'h00,4'd10),                      // R10
              fB(8'h55,1'b0,1'b0,1'b0,8'h00,4'd2),                       // R2 trailing byte
        fS(), fB(8'hEB,1'b0,1'b0,1'b0,8'h00,4'd10),                      // R10
        fS(), fB(8'hEA,1'b1,1'b0,1'b1,8'h00,4'd9),  fP(),               // R9 set hs
        fS(), fB(8'hBA,1'b1,1'b0,1'b1,8'h00,4'd3),                       // R3
              fB(8'h13,1'b1,1'b0,1'b1,8'h00,4'd3),
              fB(8'hC4,1'b1,1'b1,1'b1,8'h13,4'd4),                       // R4 write
              fB(8'h77,1'b0,1'b0,1'b1,8'h00,4'd4), fP(),
        fS(), fB(8'hB0,1'b0,1'b0,1'b1,8'h00,4'd2),                       // R2 mismatch
              fB(8'h02,1'b0,1'b0,1'b1,8'h00,4'd2),
              fB(8'h11,1'b0,1'b0,1'b1,8'h00,4'd2),
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd6),
              fB(8'h60,1'b1,1'b0,1'b1,8'h00,4'd7), fP(),                 // R7 unlocked
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd6),
              fB(8'h55,1'b0,1'b0,1'b1,8'h00,4'd6),                       // R6 bad tag
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd12),
              fB(8'h6F,1'b1,1'b0,1'b1,8'h00,4'd12),
        fS(), fB(8'hBA,1'b1,1'b0,1'b1,8'h00,4'd12),                      // R12 abort
              fB(8'h05,1'b1,1'b0,1'b1,8'h00,4'd12),
              fB(8'h99,1'b1,1'b1,1'b1,8'h05,4'd12),
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd6),
              fB(8'h63,1'b1,1'b0,1'b1,8'h00,4'd6),
              fB(8'hFF,1'b1,1'b0,1'b1,8'h00,4'd6), fP(),                 // R6 sets lock
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd7),
              fB(8'h60,1'b0,1'b0,1'b1,8'h00,4'd7), fP(),                 // R7 locked
        fS(), fB(8'hBA,1'b1,1'b0,1'b1,8'h00,4'd3),
              fB(8'h07,1'b1,1'b0,1'b1,8'h00,4'd3),
              fB(8'hAB,1'b0,1'b0,1'b1,8'h00,4'd5),                       // R5 refused
              fB(8'h12,1'b0,1'b0,1'b1,8'h00,4'd5),
        fS(), fB(8'h2A,1'b1,1'b0,1'b1,8'h00,4'd8),
              fB(8'h60,1'b0,1'b0,1'b1,8'h00,4'd8),                       // R8
              fB(8'h00,1'b0,1'b0,1'b1,8'h00,4'd8), fP(),
              fB(8'hDA,1'b0,1'b0,1'b1,8'h00,4'd12),                      // R12 no start
        fS(), fB(8'hEB,1'b1,1'b0,1'b1,8'h00,4'd12)
    };

    task automatic check(input bit ok, input int req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_evt = 1'b1;
        @(negedge clk) start_evt = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_evt = 1'b1;
        @(negedge clk) stop_evt = 1'b0;
    endtask

    // Send one byte; returns sampled {resp_vld, resp_ack, reg_we, speed_hs}.
    task automatic send(input logic [7:0] d, output logic [3:0] obs,
                        output logic [ADDR_W-1:0] oa, output logic [7:0] od);
        @(negedge clk) begin byte_vld = 1'b1; byte_data = d; end
        @(negedge clk) byte_vld = 1'b0;
        obs = {resp_vld, resp_ack, reg_we, speed_hs};
        oa  = reg_addr;
        od  = reg_wdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [3:0]        obs;
        logic [ADDR_W-1:0] oa;
        logic [7:0]        od;

        repeat (3) @(negedge clk);
        // R11: reset state.
        check(resp_vld == 1'b0 && reg_we == 1'b0 && speed_hs == 1'b1, 11,
              {resp_vld, reg_we, speed_hs}, 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: no answer with no byte.
        check(resp_vld == 1'b0, 1, resp_vld, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [24:0] e;
            e = VEC[i];
            case (e[24:23])
                2'd1: pulse_start();
                2'd2: pulse_stop();
                default: begin
                    send(e[22:15], obs, oa, od);
                    // R1 framing plus per-entry requirement.
                    check(obs == {1'b1, e[14], e[13], e[12]}, int'(e[3:0]),
                          obs, {1'b1, e[14], e[13], e[12]});
                    if (e[13])
                        check(oa == e[4 +: ADDR_W] && od == e[22:15], 4,
                              {oa, od}, {e[4 +: ADDR_W], e[22:15]});
                end
            endcase
        end

        // R1: answer drops the cycle after.
        @(negedge clk);
        check(resp_vld == 1'b0, 1, resp_vld, 1'b0);

        // R2: security write with read direction is refused.
        pulse_start();
        send(8'hBB, obs, oa, od);
        check(obs[3:1] == 3'b100, 2, obs[3:1], 3'b100);

        // R12: stop in the middle of a write drops it.
        pulse_start();
        send(8'hBA, obs, oa, od);
        send(8'h01, obs, oa, od);
        pulse_stop();
        send(8'h22, obs, oa, od);
        check(obs[3:1] == 3'b100, 12, obs[3:1], 3'b100);

        // R9: set std then confirm on port, before reset test.
        pulse_start();
        send(8'hDA, obs, oa, od);
        check(obs == 4'b1100, 9, obs, 4'b1100);

        // R11: reset clears the lock and restores high speed.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check(speed_hs == 1'b1 && resp_vld == 1'b0, 11,
              {speed_hs, resp_vld}, 2'b10);
        pulse_start();
        send(8'h2A, obs, oa, od);
        send(8'h60, obs, oa, od);
        check(obs[3:2] == 2'b11, 11, obs[3:2], 2'b11);   // unlocked again
        pulse_stop();

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule